// File: doc/BRIEF.md
# Cascadable 16-bit Bit-Slice ALU Datapath

This block is the arithmetic core of a microprogrammed processor or controller. It holds a 16-word by 16-bit register file with two read addresses and one write address, a Q working register that can shift, and an eight-function ALU. A 9-bit microinstruction steers each cycle. The instruction has three fields: one picks the operand pair (R, S) from the register outputs, Q, the direct data input and zero; one picks the ALU function; one picks where the result goes, and how it shifts on the way.

Shifts move bits toward either end of the word. The vacated bit comes in on an edge input, and the bit that leaves goes out on an edge output. Each direction has its own enable. Two slices can therefore be chained into a wider word by wiring the shift pins of one slice to its neighbour. Carry-in and carry-out chain in the same way. The Y output is forced to zero when the output enable is low, and a valid flag reports that state.

Top module: `slice_datapath`

## Requirements
- R1: After the asynchronous reset rst_ni, all 16 register-file words and Q read as zero.
- R2: instr_i[2:0] selects the operand pair (R,S): 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). A and B are the register words at addr_a_i and addr_b_i.
- R3: instr_i[5:3] selects F: 0=R+S+cin, 1=S+~R+cin, 2=R+~S+cin, 3=R|S, 4=R&S, 5=~R&S, 6=R^S, 7=~(R^S).
- R4: For codes 0..2, cout_o is the carry out of bit 15, and ovf_o is the carry into bit 15 XOR the carry out of bit 15. For codes 3..7, cout_o=0 and ovf_o=0. sign_o=F[15], and zero_o is high when F is 0.
- R5: instr_i[8:6]=0 loads F into Q. Code 1 loads nothing. In both cases Y shows F.
- R6: Code 2 writes F to word B, and Y shows the A operand. Code 3 writes F to word B, and Y shows F.
- R7: Codes 4 and 5 write {ram_hi_i, F[15:1]} to word B, drive ram_lo_o=F[0] and q_lo_o=Q[0], and raise dn_oe_o. Code 4 also loads Q with {q_hi_i, Q[15:1]}. Code 5 holds Q.
- R8: Codes 6 and 7 write {F[14:0], ram_lo_i} to word B, drive ram_hi_o=F[15] and q_hi_o=Q[15], and raise up_oe_o. Code 6 also loads Q with {Q[14:0], q_lo_i}. Code 7 holds Q. Back-to-back shifts build on one another.
- R9: When the write address equals a read address, the operands and Y of that cycle use the value before the write. The new value is visible from the next cycle.
- R10: With oe_i low, y_o is 0 and valid_o is low. Register state still updates.
- R11: For codes 0..3, all four shift outputs and both direction enables are 0. At most one direction enable is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 9 | Microinstruction: [2:0] operands, [5:3] function, [8:6] destination |
| addr_a_i | input | 4 | Read address A |
| addr_b_i | input | 4 | Read and write address B |
| d_i | input | 16 | Direct data operand |
| cin_i | input | 1 | Carry in |
| oe_i | input | 1 | Y output enable |
| ram_hi_i | input | 1 | Fill bit for the top of the register-file word on a down shift |
| ram_lo_i | input | 1 | Fill bit for the bottom of the register-file word on an up shift |
| q_hi_i | input | 1 | Fill bit for the top of Q on a down shift |
| q_lo_i | input | 1 | Fill bit for the bottom of Q on an up shift |
| y_o | output | 16 | Result bus |
| valid_o | output | 1 | Y is being driven |
| cout_o | output | 1 | Carry out |
| ovf_o | output | 1 | Signed overflow |
| sign_o | output | 1 | F[15] |
| zero_o | output | 1 | F is all zero |
| ram_lo_o | output | 1 | Bit shifted out of the bottom of F |
| ram_hi_o | output | 1 | Bit shifted out of the top of F |
| q_lo_o | output | 1 | Bit shifted out of the bottom of Q |
| q_hi_o | output | 1 | Bit shifted out of the top of Q |
| dn_oe_o | output | 1 | Down-shift outputs are valid |
| up_oe_o | output | 1 | Up-shift outputs are valid |

## Verification
A read of a register word and a write to the same word can fall in the same cycle. So can a Q shift and a Q read used as an operand. Directed cases set addr_a_i and addr_b_i equal under destinations 2 and 3, and issue runs of consecutive Q shifts with sources that read Q. Random microinstructions then cover many more such overlaps. Each cycle is checked against a bench model that computes Y from the state held before the edge and commits the write afterward. A stale or early value in either function shows up as a Y mismatch, or later in a readback of the word.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [2:0] {
    SRC_AQ, SRC_AB, SRC_ZQ, SRC_ZB, SRC_ZA, SRC_DA, SRC_DQ, SRC_DZ
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUBR, FN_SUBS, FN_OR, FN_AND, FN_NOTRS, FN_XOR, FN_XNOR
  } fn_e;

  typedef enum logic [2:0] {
    DST_QREG, DST_NOP, DST_RAMA, DST_RAMF, DST_RAMQD, DST_RAMD, DST_RAMQU, DST_RAMU
  } dst_e;
endpackage

// File: rtl/slice_regfile.sv
module slice_regfile #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic          we_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  a_o,
  output logic [W-1:0]  b_o
);
  logic [W-1:0] mem_q [DEPTH];

  // reads see pre-edge contents; write commits on the edge
  assign a_o = mem_q[ra_i];
  assign b_o = mem_q[rb_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[rb_i] <= wd_i;
    end
  end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  logic         cin_i,
  input  fn_e          fn_i,
  output logic [W-1:0] f_o,
  output logic         cout_o,
  output logic         ovf_o,
  output logic         sign_o,
  output logic         zero_o
);
  logic [W-1:0] x, y;
  logic [W:0]   sum;
  logic [W-1:0] low;
  logic         arith;

  always_comb begin
    arith = 1'b1;
    x     = r_i;
    y     = s_i;
    unique case (fn_i)
      FN_ADD:  begin x = r_i;  y = s_i;  end
      FN_SUBR: begin x = ~r_i; y = s_i;  end
      FN_SUBS: begin x = r_i;  y = ~s_i; end
      default: arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin_i};
  // carry into the top bit, from the lower W-1 bits alone
  assign low = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, cin_i};

  always_comb begin
    f_o = sum[W-1:0];
    unique case (fn_i)
      FN_OR:    f_o = r_i | s_i;
      FN_AND:   f_o = r_i & s_i;
      FN_NOTRS: f_o = ~r_i & s_i;
      FN_XOR:   f_o = r_i ^ s_i;
      FN_XNOR:  f_o = ~(r_i ^ s_i);
      default:  f_o = sum[W-1:0];
    endcase
  end

  assign cout_o = arith & sum[W];
  assign ovf_o  = arith & (sum[W] ^ low[W-1]);
  assign sign_o = f_o[W-1];
  assign zero_o = (f_o == '0);
endmodule

// File: rtl/slice_dest.sv
module slice_dest
  import slice_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  dst_e         dst_i,
  input  logic [W-1:0] f_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] a_i,
  input  logic         ram_hi_i,
  input  logic         ram_lo_i,
  input  logic         q_hi_i,
  input  logic         q_lo_i,
  output logic         ram_we_o,
  output logic [W-1:0] ram_wd_o,
  output logic         q_ld_o,
  output logic [W-1:0] q_nxt_o,
  output logic [W-1:0] y_o,
  output logic         ram_lo_o,
  output logic         ram_hi_o,
  output logic         q_lo_o,
  output logic         q_hi_o,
  output logic         dn_oe_o,
  output logic         up_oe_o
);
  always_comb begin
    ram_we_o = 1'b0;
    ram_wd_o = f_i;
    q_ld_o   = 1'b0;
    q_nxt_o  = f_i;
    y_o      = f_i;
    ram_lo_o = 1'b0;
    ram_hi_o = 1'b0;
    q_lo_o   = 1'b0;
    q_hi_o   = 1'b0;
    dn_oe_o  = 1'b0;
    up_oe_o  = 1'b0;
    unique case (dst_i)
      DST_QREG: q_ld_o = 1'b1;
      DST_NOP:  ;
      DST_RAMA: begin ram_we_o = 1'b1; y_o = a_i; end
      DST_RAMF: ram_we_o = 1'b1;
      DST_RAMQD, DST_RAMD: begin
        ram_we_o = 1'b1;
        ram_wd_o = {ram_hi_i, f_i[W-1:1]};
        ram_lo_o = f_i[0];
        q_lo_o   = q_i[0];
        dn_oe_o  = 1'b1;
        if (dst_i == DST_RAMQD) begin
          q_ld_o  = 1'b1;
          q_nxt_o = {q_hi_i, q_i[W-1:1]};
        end
      end
      DST_RAMQU, DST_RAMU: begin
        ram_we_o = 1'b1;
        ram_wd_o = {f_i[W-2:0], ram_lo_i};
        ram_hi_o = f_i[W-1];
        q_hi_o   = q_i[W-1];
        up_oe_o  = 1'b1;
        if (dst_i == DST_RAMQU) begin
          q_ld_o  = 1'b1;
          q_nxt_o = {q_i[W-2:0], q_lo_i};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [8:0]    instr_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [W-1:0]  d_i,
  input  logic          cin_i,
  input  logic          oe_i,
  input  logic          ram_hi_i,
  input  logic          ram_lo_i,
  input  logic          q_hi_i,
  input  logic          q_lo_i,
  output logic [W-1:0]  y_o,
  output logic          valid_o,
  output logic          cout_o,
  output logic          ovf_o,
  output logic          sign_o,
  output logic          zero_o,
  output logic          ram_lo_o,
  output logic          ram_hi_o,
  output logic          q_lo_o,
  output logic          q_hi_o,
  output logic          dn_oe_o,
  output logic          up_oe_o
);
  src_e         src;
  fn_e          fn;
  dst_e         dst;
  logic [W-1:0] a_rd, b_rd, q_q, r_op, s_op, alu_f, q_nxt, ram_wd, y_sel;
  logic         ram_we, q_ld;

  assign src = src_e'(instr_i[2:0]);
  assign fn  = fn_e'(instr_i[5:3]);
  assign dst = dst_e'(instr_i[8:6]);

  always_comb begin
    r_op = '0;
    s_op = '0;
    unique case (src)
      SRC_AQ:  begin r_op = a_rd; s_op = q_q;  end
      SRC_AB:  begin r_op = a_rd; s_op = b_rd; end
      SRC_ZQ:  s_op = q_q;
      SRC_ZB:  s_op = b_rd;
      SRC_ZA:  s_op = a_rd;
      SRC_DA:  begin r_op = d_i;  s_op = a_rd; end
      SRC_DQ:  begin r_op = d_i;  s_op = q_q;  end
      SRC_DZ:  r_op = d_i;
      default: ;
    endcase
  end

  slice_regfile #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_rf (
    .clk_i, .rst_ni,
    .ra_i (addr_a_i), .rb_i (addr_b_i),
    .we_i (ram_we),   .wd_i (ram_wd),
    .a_o  (a_rd),     .b_o  (b_rd)
  );

  slice_alu #(.W(W)) u_alu (
    .r_i (r_op), .s_i (s_op), .cin_i, .fn_i (fn),
    .f_o (alu_f), .cout_o, .ovf_o, .sign_o, .zero_o
  );

  slice_dest #(.W(W)) u_dst (
    .dst_i (dst), .f_i (alu_f), .q_i (q_q), .a_i (a_rd),
    .ram_hi_i, .ram_lo_i, .q_hi_i, .q_lo_i,
    .ram_we_o (ram_we), .ram_wd_o (ram_wd),
    .q_ld_o (q_ld), .q_nxt_o (q_nxt), .y_o (y_sel),
    .ram_lo_o, .ram_hi_o, .q_lo_o, .q_hi_o, .dn_oe_o, .up_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (q_ld) q_q <= q_nxt;
  end

  assign y_o     = oe_i ? y_sel : '0;
  assign valid_o = oe_i;
endmodule

// File: rtl/slice_datapath_chk.sv
module slice_datapath_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [8:0]   instr_i,
  input logic         q_lo_i,
  input logic         q_hi_i,
  input logic         cout_o,
  input logic         ovf_o,
  input logic         dn_oe_o,
  input logic         up_oe_o,
  input logic [W-1:0] q_q,
  input logic [W-1:0] alu_f
);
  // R11
  dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dn_oe_o, up_oe_o}));

  // R4
  logic_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[5:3] >= 3'd3) |-> (!cout_o && !ovf_o));

  // R5
  q_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[8:6] == 3'd0) |=> (q_q == $past(alu_f)));

  // R8
  q_up_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[8:6] == 3'd6) |=> (q_q[0] == $past(q_lo_i)));

  // R7
  q_dn_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[8:6] == 3'd4) |=> (q_q[W-1] == $past(q_hi_i)));

  // R7
  q_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[8:6] == 3'd5 || instr_i[8:6] == 3'd7) |=> $stable(q_q));
endmodule

bind slice_datapath slice_datapath_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .instr_i, .q_lo_i, .q_hi_i, .cout_o, .ovf_o,
  .dn_oe_o, .up_oe_o, .q_q (q_q), .alu_f (alu_f)
);

// File: tb/tb_slice_datapath.sv
`timescale 1ns/1ps
module tb_slice_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  instr = 9'o113;
  logic [3:0]  aa = '0, ab = '0;
  logic [15:0] d = '0;
  logic        cin = 1'b0, oe = 1'b1;
  logic        rhi = 1'b0, rlo = 1'b0, qhi = 1'b0, qlo = 1'b0;
  logic [15:0] y;
  logic        valid, cout, ovf, sign, zero, rlo_o, rhi_o, qlo_o, qhi_o, dn_oe, up_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_ram [16];
  logic [15:0] m_q;

  always #10 clk = ~clk;

  slice_datapath dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .addr_a_i(aa), .addr_b_i(ab),
    .d_i(d), .cin_i(cin), .oe_i(oe), .ram_hi_i(rhi), .ram_lo_i(rlo),
    .q_hi_i(qhi), .q_lo_i(qlo), .y_o(y), .valid_o(valid), .cout_o(cout),
    .ovf_o(ovf), .sign_o(sign), .zero_o(zero), .ram_lo_o(rlo_o),
    .ram_hi_o(rhi_o), .q_lo_o(qlo_o), .q_hi_o(qhi_o), .dn_oe_o(dn_oe), .up_oe_o(up_oe)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare mid-low-phase, commit model
  task automatic cycle(logic [8:0] ins, logic [3:0] a, logic [3:0] b, logic [15:0] dd,
                       logic ci, logic en, logic [3:0] fills, string tag);
    logic [15:0] ra, rb, r, s, x, yy, f, ey, wd, qn;
    logic [16:0] sum;
    logic [15:0] low;
    logic co, ov, ar, we, ql;
    logic [5:0] sh;
    @(negedge clk);
    instr = ins; aa = a; ab = b; d = dd; cin = ci; oe = en;
    {rhi, rlo, qhi, qlo} = fills;
    #5;
    ra = m_ram[a]; rb = m_ram[b];
    case (ins[2:0])
      3'd0: begin r = ra; s = m_q; end
      3'd1: begin r = ra; s = rb; end
      3'd2: begin r = '0; s = m_q; end
      3'd3: begin r = '0; s = rb; end
      3'd4: begin r = '0; s = ra; end
      3'd5: begin r = dd; s = ra; end
      3'd6: begin r = dd; s = m_q; end
      default: begin r = dd; s = '0; end
    endcase
    ar = (ins[5:3] <= 3'd2);
    x = (ins[5:3] == 3'd1) ? ~r : r;
    yy = (ins[5:3] == 3'd2) ? ~s : s;
    sum = {1'b0, x} + {1'b0, yy} + {16'd0, ci};
    low = {1'b0, x[14:0]} + {1'b0, yy[14:0]} + {15'd0, ci};
    case (ins[5:3])
      3'd3: f = r | s;
      3'd4: f = r & s;
      3'd5: f = ~r & s;
      3'd6: f = r ^ s;
      3'd7: f = ~(r ^ s);
      default: f = sum[15:0];
    endcase
    co = ar & sum[16];
    ov = ar & (sum[16] ^ low[15]);
    we = (ins[8:6] >= 3'd2);
    ql = 1'b0; qn = m_q; wd = f; sh = '0;
    case (ins[8:6])
      3'd0: begin ql = 1'b1; qn = f; end
      3'd4, 3'd5: begin
        wd = {rhi, f[15:1]}; sh = {1'b1, 1'b0, f[0], 1'b0, m_q[0], 1'b0};
        if (ins[8:6] == 3'd4) begin ql = 1'b1; qn = {qhi, m_q[15:1]}; end
      end
      3'd6, 3'd7: begin
        wd = {f[14:0], rlo}; sh = {1'b0, 1'b1, 1'b0, f[15], 1'b0, m_q[15]};
        if (ins[8:6] == 3'd6) begin ql = 1'b1; qn = {m_q[14:0], qlo}; end
      end
      default: ;
    endcase
    ey = !en ? 16'h0 : (ins[8:6] == 3'd2) ? ra : f;
    // sh = {dn_oe, up_oe, ram_lo, ram_hi, q_lo, q_hi}
    chk(tag != "" ? tag : (!en ? "R10" : (ar ? "R3" : "R2")), "y", {16'h0, y}, {16'h0, ey});
    chk("R10", "valid", {31'h0, valid}, {31'h0, en});
    chk("R4", "flags", {28'h0, cout, ovf, sign, zero}, {28'h0, co, ov, f[15], (f == 16'h0)});
    chk(ins[8:6] < 3'd4 ? "R11" : (ins[8:6] < 3'd6 ? "R7" : "R8"), "shift",
        {26'h0, dn_oe, up_oe, rlo_o, rhi_o, qlo_o, qhi_o}, {26'h0, sh});
    if (we) m_ram[b] = wd;
    if (ql) m_q = qn;
  endtask

  // readback through src (0,A), OR, no destination
  task automatic rd_ram(logic [3:0] a, string tag);
    cycle(9'b001_011_100, a, 4'd0, 16'h0, 1'b0, 1'b1, 4'h0, tag);
  endtask
  task automatic rd_q(string tag);
    cycle(9'b001_011_010, 4'd0, 4'd0, 16'h0, 1'b0, 1'b1, 4'h0, tag);
  endtask
  task automatic wr_ram(logic [3:0] b, logic [15:0] v);
    cycle(9'b011_011_111, 4'd0, b, v, 1'b0, 1'b1, 4'h0, "R6");
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_ram[i] = '0;
    m_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int i = 0; i < 16; i++) rd_ram(4'(i), "R1");
    rd_q("R1");

    for (int i = 0; i < 16; i++) wr_ram(4'(i), 16'(($urandom & 16'hffff)));
    for (int i = 0; i < 16; i++) rd_ram(4'(i), "R6");

    // R4 corners: signed overflow, carry, zero
    wr_ram(4'd1, 16'h7fff);
    cycle(9'b001_000_101, 4'd1, 4'd0, 16'h0001, 1'b0, 1'b1, 4'h0, "R4");
    wr_ram(4'd2, 16'hffff);
    cycle(9'b001_000_101, 4'd2, 4'd0, 16'h0001, 1'b0, 1'b1, 4'h0, "R4");
    cycle(9'b001_001_101, 4'd2, 4'd0, 16'hffff, 1'b1, 1'b1, 4'h0, "R4");

    // R9: same-address read-modify-write
    wr_ram(4'd5, 16'h1234);
    cycle(9'b011_000_001, 4'd5, 4'd5, 16'h0, 1'b0, 1'b1, 4'h0, "R9");
    rd_ram(4'd5, "R9");
    wr_ram(4'd6, 16'h00ff);
    cycle(9'b010_000_101, 4'd6, 4'd6, 16'h0001, 1'b0, 1'b1, 4'h0, "R9");
    rd_ram(4'd6, "R9");

    // R5: Q load and no-load
    cycle(9'b000_011_111, 4'd0, 4'd0, 16'h8001, 1'b0, 1'b1, 4'h0, "R5");
    cycle(9'b001_011_111, 4'd0, 4'd0, 16'h5555, 1'b0, 1'b1, 4'h0, "R5");
    rd_q("R5");

    // R8 / R7: back-to-back Q shifts read through Q operand
    cycle(9'b110_011_010, 4'd0, 4'd7, 16'h0, 1'b0, 1'b1, 4'b0101, "R8");
    cycle(9'b110_011_010, 4'd0, 4'd7, 16'h0, 1'b0, 1'b1, 4'b1010, "R8");
    cycle(9'b110_011_010, 4'd0, 4'd7, 16'h0, 1'b0, 1'b1, 4'b0101, "R8");
    rd_q("R8");
    cycle(9'b111_011_010, 4'd0, 4'd8, 16'h0, 1'b0, 1'b1, 4'b0101, "R8");
    rd_q("R8");
    cycle(9'b100_011_010, 4'd0, 4'd9, 16'h0, 1'b0, 1'b1, 4'b1010, "R7");
    cycle(9'b100_011_010, 4'd0, 4'd9, 16'h0, 1'b0, 1'b1, 4'b1010, "R7");
    cycle(9'b101_011_010, 4'd0, 4'd9, 16'h0, 1'b0, 1'b1, 4'b0101, "R7");
    rd_q("R7");
    rd_ram(4'd9, "R7");

    // R10: output disabled but state updates
    cycle(9'b011_011_111, 4'd0, 4'd3, 16'hbeef, 1'b0, 1'b0, 4'h0, "R10");
    rd_ram(4'd3, "R10");

    for (int n = 0; n < 4000; n++) begin
      cycle(9'($urandom), 4'($urandom), 4'($urandom), 16'($urandom), 1'($urandom),
            (($urandom & 7) != 0), 4'($urandom), "");
    end
    for (int i = 0; i < 16; i++) rd_ram(4'(i), "R6");
    rd_q("R5");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule